// File: doc/BRIEF.md
# Two-Level Fixed-Priority DMA Request Arbiter

This block decides which of seven DMA request lines gets the bus next. It is built as two groups of four inputs. The lower group (channels 0 to 3) feeds its combined request into the top slot of the upper group (slot 4). Slots 5 to 7 of the upper group are ordinary channels. A pending, unmasked request raises a hold request towards the processor. Once hold-acknowledge comes back, the arbiter picks the winner by fixed priority: channel 0 is the highest and channel 7 the lowest. It then freezes that winner and drives its acknowledge line until the granted channel pulses session-done.

A running session is never preempted, even by a higher-priority request. New requests are considered only after the done pulse. At that point the acknowledge falls, and the next clock re-arbitrates among whatever is still pending. Hold stays asserted if any request remains. A side flag tells the datapath whether the granted channel is a byte-wide channel (0 to 3) or a word-wide channel (5 to 7).

The control is a three-state machine:

- `ST_IDLE`: nothing pending.
- `ST_HOLD`: hold raised, waiting for hold-acknowledge.
- `ST_XFER`: acknowledge driven, session running.

Its transitions are:

- IDLE to HOLD on any eligible request.
- HOLD to IDLE when every eligible request has gone.
- HOLD to XFER when hold-acknowledge is seen with a request still eligible. The winner is latched on that same edge.
- XFER to HOLD on done with requests still eligible.
- XFER to IDLE on done with none eligible.

Top module: `dma_cascade_arb`

## Requirements
- R1: While reset is active, and on the first clock after it is released, hold_o, ack_o and wide_o are all zero.
- R2: A request is eligible when its bit in req_i is 1, its bit in mask_i is 0, and it is not bit 4. From idle, hold_o rises on the clock after any request becomes eligible.
- R3: ack_o stays zero until hld_ack_i is sampled high with a request eligible. The acknowledge then appears on the next clock.
- R4: Among the requests eligible at the grant edge, the lowest channel number wins. Every channel 0 to 3 ranks above every channel 5 to 7.
- R5: Bit 4 of req_i is the cascade link. It never raises hold_o, and ack_o bit 4 is never set.
- R6: A request whose mask_i bit is 1 never raises hold_o and is never acknowledged.
- R7: While a session runs, ack_o keeps its value until done_i is sampled high, whatever other requests arrive.
- R8: When done_i is sampled high during a session and requests are still eligible, ack_o falls on the next clock while hold_o stays high. With hld_ack_i high, the next winner is acknowledged one clock later.
- R9: When done_i ends a session and nothing is eligible, hold_o and ack_o both fall on the next clock.
- R10: wide_o is 1 exactly while a channel in the range 5 to 7 is acknowledged.
- R11: done_i has no effect when no session is running.
- R12: If every eligible request is withdrawn or masked before the grant, hold_o falls on the next clock and no acknowledge is issued.
- R13: At most one bit of ack_o is set at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request lines, bit n is channel n; bit 4 is the cascade link |
| mask_i | input | 8 | Per-channel mask, 1 blocks that channel |
| hld_ack_i | input | 1 | Hold-acknowledge from the processor |
| done_i | input | 1 | Session-done pulse from the granted channel |
| hold_o | output | 1 | Hold request towards the processor |
| ack_o | output | 8 | One-hot acknowledge, bit n for channel n |
| wide_o | output | 1 | Granted channel is a word-wide channel |

## Verification
Suppose the latched winner were corrupted or not frozen. The ack_o bit would then change within a session on the next clock, or the wrong bit would be acknowledged on the clock right after hold-acknowledge. Both show up in the cycle they happen. A state register stuck in the wrong state shows as hold_o failing to rise or fall one clock after the eligible set changes. It also shows as a missing one-clock acknowledge gap after done. The priority sweep walks every usable channel through a grant, so a wrong group link or priority slot is caught on the first misordered acknowledge.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_XFER = 2'd2
    } arb_state_e;

endpackage

// File: rtl/dma_prio_enc.sv
module dma_prio_enc #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o,
    output logic         any_o
);

    // blocked[i] is set when some lower index (higher priority) requests
    logic [N-1:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 1; i < N; i++) begin : g_chain
        assign blocked[i] = blocked[i-1] | req_i[i-1];
    end

    assign gnt_o = req_i & ~blocked;
    assign any_o = |req_i;

endmodule

// File: rtl/dma_cascade_pick.sv
module dma_cascade_pick #(
    parameter int GRP = 4
) (
    input  logic [2*GRP-1:0] elig_i,
    output logic [2*GRP-1:0] pick_o
);

    localparam int NCH = 2 * GRP;

    logic [GRP-1:0] low_gnt;
    logic           low_any;
    logic [GRP-1:0] up_req;
    logic [GRP-1:0] up_gnt;
    logic           up_any;

    dma_prio_enc #(.N(GRP)) u_low (
        .req_i (elig_i[GRP-1:0]),
        .gnt_o (low_gnt),
        .any_o (low_any)
    );

    // slot 0 of the upper group is the link from the lower group
    assign up_req = {elig_i[NCH-1:GRP+1], low_any};

    dma_prio_enc #(.N(GRP)) u_up (
        .req_i (up_req),
        .gnt_o (up_gnt),
        .any_o (up_any)
    );

    always_comb begin
        pick_o = '0;
        if (up_any) begin
            pick_o[NCH-1:GRP+1] = up_gnt[GRP-1:1];
            if (up_gnt[0]) begin
                pick_o[GRP-1:0] = low_gnt;
            end
        end
    end

endmodule

// File: rtl/dma_cascade_arb.sv
module dma_cascade_arb
    import dma_arb_pkg::*;
#(
    parameter int GRP = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*GRP-1:0]     req_i,
    input  logic [2*GRP-1:0]     mask_i,
    input  logic                 hld_ack_i,
    input  logic                 done_i,
    output logic                 hold_o,
    output logic [2*GRP-1:0]     ack_o,
    output logic                 wide_o
);

    localparam int NCH  = 2 * GRP;
    localparam int LINK = GRP;

    localparam logic [NCH-1:0] LINK_BIT = NCH'(1) << LINK;

    arb_state_e     state_q, state_d;
    logic [NCH-1:0] win_q;
    logic [NCH-1:0] elig;
    logic [NCH-1:0] pick;
    logic           pending;
    logic           take;

    assign elig    = req_i & ~mask_i & ~LINK_BIT;
    assign pending = |elig;
    assign take    = (state_q == ST_HOLD) && pending && hld_ack_i;

    dma_cascade_pick #(.GRP(GRP)) u_pick (
        .elig_i (elig),
        .pick_o (pick)
    );

    // state register and frozen winner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                win_q <= pick;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pending) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!pending)       state_d = ST_IDLE;
                else if (hld_ack_i) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (done_i) state_d = pending ? ST_HOLD : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hold_o = 1'b0;
        ack_o  = '0;
        wide_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HOLD: hold_o = 1'b1;
            ST_XFER: begin
                hold_o = 1'b1;
                ack_o  = win_q;
                wide_o = |win_q[NCH-1:GRP+1];
            end
            default: ;
        endcase
    end

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o)); // R13

    AST_ACK_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> hold_o); // R3

    AST_GRANT_AFTER_HLDA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|ack_o) |-> $past(hld_ack_i)); // R3

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_o) && !done_i) |=> (ack_o == $past(ack_o))); // R7

    AST_DONE_DROPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_o) && done_i) |=> (ack_o == '0)); // R8

    AST_LINK_NEVER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o[LINK]); // R5

    AST_WIDE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        wide_o |-> (|ack_o[NCH-1:GRP+1])); // R10

    AST_GRANT_WAS_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|ack_o) |-> (($past(req_i & ~mask_i) & ack_o) != '0)); // R6

endmodule

// File: tb/dma_cascade_arb_tb.sv
`timescale 1ns/1ps
module dma_cascade_arb_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic [7:0] mask_i = '0;
    logic       hld_ack_i = 1'b0;
    logic       done_i = 1'b0;
    logic       hold_o;
    logic [7:0] ack_o;
    logic       wide_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dma_cascade_arb #(.GRP(4)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .mask_i    (mask_i),
        .hld_ack_i (hld_ack_i),
        .done_i    (done_i),
        .hold_o    (hold_o),
        .ack_o     (ack_o),
        .wide_o    (wide_o)
    );

    // row fields: req[27:20] mask[19:12] hlda[11] done[10] hold[9] ack[8:1] wide[0]
    localparam int NV = 15;
    localparam logic [27:0] VEC [NV] = '{
        {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}, // R1 idle
        {8'h80, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0}, // R2 hold rises
        {8'h80, 8'h00, 1'b1, 1'b0, 1'b1, 8'h80, 1'b1}, // R3 grant ch7, R10
        {8'h81, 8'h00, 1'b1, 1'b0, 1'b1, 8'h80, 1'b1}, // R7 no preempt
        {8'h81, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0}, // R8 done, gap
        {8'h01, 8'h00, 1'b1, 1'b0, 1'b1, 8'h01, 1'b0}, // R8 regrant ch0
        {8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0}, // R9 all released
        {8'h10, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R5 link ignored
        {8'h0C, 8'h04, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0}, // R6 ch2 masked
        {8'h6C, 8'h04, 1'b1, 1'b0, 1'b1, 8'h08, 1'b0}, // R4 ch3 over ch5
        {8'h60, 8'h04, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0}, // R8
        {8'h60, 8'h04, 1'b1, 1'b0, 1'b1, 8'h20, 1'b1}, // R4 ch5, R10
        {8'h40, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0}, // R8
        {8'h40, 8'h40, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R12 masked away
        {8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0}  // R11 stray done
    };
    localparam int VTAG [NV] = '{1, 2, 3, 7, 8, 8, 9, 5, 6, 4, 8, 4, 8, 12, 11};

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input int rq, input logic eh, input logic [7:0] ea, input logic ew);
        #8;
        total++;
        if (hold_o !== eh || ack_o !== ea || wide_o !== ew) begin
            bad++;
            $display("FAIL R%0d: hold=%b ack=%h wide=%b expected hold=%b ack=%h wide=%b",
                     rq, hold_o, ack_o, wide_o, eh, ea, ew);
        end
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] left;
        logic [7:0] exp;
        // R1 during reset
        step();
        check(1, 1'b0, 8'h00, 1'b0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            req_i     = VEC[v][27:20];
            mask_i    = VEC[v][19:12];
            hld_ack_i = VEC[v][11];
            done_i    = VEC[v][10];
            step();
            check(VTAG[v], VEC[v][9], VEC[v][8:1], VEC[v][0]);
        end
        done_i = 1'b0;

        // R3: waiting without hold-acknowledge gives no grant
        req_i = 8'h02; mask_i = 8'h00; hld_ack_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            check(3, 1'b1, 8'h00, 1'b0);
        end
        hld_ack_i = 1'b1;
        step();
        check(3, 1'b1, 8'h02, 1'b0);
        req_i = 8'h00; done_i = 1'b1;
        step();
        check(9, 1'b0, 8'h00, 1'b0);
        done_i = 1'b0;

        // R4 sweep: every usable channel plus the link line requesting
        req_i = 8'hFF; hld_ack_i = 1'b1;
        step();
        check(2, 1'b1, 8'h00, 1'b0);
        left = 8'hEF;
        for (int k = 0; k < 7; k++) begin
            exp = left & (~left + 8'd1);
            step();
            check(4, 1'b1, exp, |exp[7:5]);
            left = left & ~exp;
            req_i = left | 8'h10;
            done_i = 1'b1;
            step();
            check(8, left != 8'h00, 8'h00, 1'b0);
            done_i = 1'b0;
        end

        // R12: request dropped while waiting
        req_i = 8'h00; hld_ack_i = 1'b0;
        step();
        req_i = 8'h04;
        step();
        check(2, 1'b1, 8'h00, 1'b0);
        req_i = 8'h00;
        step();
        check(12, 1'b0, 8'h00, 1'b0);

        // R1: reset in the middle of a session
        req_i = 8'h20; hld_ack_i = 1'b1;
        step();
        step();
        check(10, 1'b1, 8'h20, 1'b1);
        rst_n = 1'b0;
        #1;
        check(1, 1'b0, 8'h00, 1'b0);
        req_i = 8'h00;
        step();
        rst_n = 1'b1;
        step();
        check(1, 1'b0, 8'h00, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule